// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a bus-write front end and the program/erase engine of a word-wide flash array. Each accepted write arrives as one cycle of `wr_valid` with its address and data. The block treats the stream as multi-cycle commands that are guarded by fixed unlock writes. From those commands it issues single-cycle start, abort, suspend and resume requests to the engine. It also tells the read path whether a bus read returns the array, an identifier word or the engine status.

The decoder compares only address bits 10..0 and data bits 7..0 of command writes. The upper bits are ignored. Any write that does not fit the expected next step drops the decoder back to plain read mode.

A bypass mode lets programming take two writes instead of four. Block erase collects target blocks until a quiet window of `WIN_CYC` cycles expires, and only then launches.

The array is split into five blocks, numbered by base address:

| Block | Base address |
|---|---|
| 0 | 0x0000 |
| 1 | 0x2000 |
| 2 | 0x3000 |
| 3 | 0x4000 |
| 4 | 0x8000 |

Protection flags for the blocks come in on `prot`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_sel` is 0 (array), `bypass_on` is 0 and every request pulse is low.
- R2: Only address bits 10..0 and data bits 7..0 of command writes are compared. Setting higher bits changes nothing.
- R3: The unlock prefix is 0xAA at 0x555, then 0x55 at 0x2AA. A write that does not fit the next expected step returns the decoder to read mode, so a later fragment of a command starts nothing.
- R4: Prefix plus 0x90 at 0x555 selects identifier reads, with `rd_sel` = 1. `id_word` is registered one cycle after `rd_addr` and depends on `rd_addr[1:0]`:
  - 00 gives `MFR_CODE` (default 0x0020).
  - 01 gives `DEV_CODE` (default 0x0097).
  - 10 gives the protect flag of the block that holds `rd_addr`, as 0x0001 or 0x0000.
- R5: Prefix plus 0xA0 at 0x555, then a write of target address and data, pulses `start_prog` for one cycle with `op_addr`/`op_data` set to the full target write, and sets `rd_sel` = 2 (status). If the target block is protected, nothing starts and the decoder returns to read mode.
- R6: A single 0xF0 write to any address, or the prefix followed by 0xF0, returns the decoder to read mode (`rd_sel` = 0) from identifier mode.
- R7: Prefix plus 0x20 at 0x555 sets `bypass_on`. In bypass mode:
  - 0xA0 followed by an address/data write starts a program.
  - 0x90 followed by 0x00 leaves bypass.
  - Every other write is ignored.
  - Reads return the array.
- R8: Prefix, 0x80 at 0x555, prefix again, then 0x10 at 0x555 pulses `start_erase` with `erase_mask` equal to every unprotected block. If every block is protected, nothing starts.
- R9: The same six-write lead-in ending with 0x30 at any address adds that address's block to an erase list, and `rd_sel` becomes 2. Each further 0x30 adds a block and restarts the window. `WIN_CYC` cycles after the last 0x30, `start_erase` pulses with the unprotected listed blocks and `win_closed` rises. `win_closed` falls when the engine completes.
- R10: While an operation runs, writes are ignored, with one exception. During an erase, 0xB0 pulses `suspend_req` and sets `rd_sel` = 0; after that, 0x30 pulses `resume_req` and restores `rd_sel` = 2.
- R11: `eng_done` together with `eng_fail` leaves `rd_sel` = 2. A 0xF0 write then pulses `abort_req` and returns the decoder to read mode, or to bypass mode if bypass was active.
- R12: In the error state, writes other than 0xF0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One accepted bus write this cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 16 | Current read address, used for identifier words |
| prot | input | 5 | Per-block protect flags |
| eng_done | input | 1 | Engine finished the running operation |
| eng_fail | input | 1 | Qualifies `eng_done` as failed |
| start_prog | output | 1 | One-cycle program request |
| op_addr | output | 16 | Program target address |
| op_data | output | 16 | Program target data |
| start_erase | output | 1 | One-cycle erase request |
| erase_mask | output | 5 | Blocks to erase |
| abort_req | output | 1 | One-cycle error-clear request |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| win_closed | output | 1 | Block-erase collection window has closed |
| bypass_on | output | 1 | Bypass mode active |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_word | output | 16 | Identifier or protect word for `rd_addr` |

## Verification
The hardest condition to reach is leaving the error state back into bypass mode. Getting there needs bypass entry, a bypass program, an engine completion flagged as failed, rejected writes while in the error state, and finally the clearing write, all in one run. The bench reaches it with a directed sequence, and it also times the block-erase window to the exact cycle after a second block is added. Seeded random stimulus covers the rest:
- unlock sequences broken at random steps;
- programs to random addresses under random protect maps;
- identifier reads with random high address bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int FLC_AW   = 16;
  localparam int FLC_DW   = 16;
  localparam int FLC_CAW  = 11;
  localparam int FLC_NBLK = 5;
  localparam int FLC_BW   = $clog2(FLC_NBLK);

  localparam logic [FLC_NBLK-1:0][FLC_AW-1:0] FLC_BLK_BASE =
    {16'h8000, 16'h4000, 16'h3000, 16'h2000, 16'h0000};

  localparam logic [FLC_CAW-1:0] ADR_UNLK1 = 11'h555;
  localparam logic [FLC_CAW-1:0] ADR_UNLK2 = 11'h2AA;

  localparam logic [1:0] RD_ARRAY  = 2'd0;
  localparam logic [1:0] RD_ID     = 2'd1;
  localparam logic [1:0] RD_STATUS = 2'd2;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_AUTO, ST_PROG, ST_E0, ST_E1, ST_E2,
    ST_WIN, ST_BUSY, ST_SUSP, ST_ERR, ST_BYP, ST_BEXIT
  } fst_t;

  typedef struct packed {
    logic       at_unlk1;
    logic       at_unlk2;
    logic [7:0] code;
  } cmd_t;

  function automatic logic [FLC_BW-1:0] blk_of(input logic [FLC_AW-1:0] a);
    blk_of = '0;
    for (int i = 0; i < FLC_NBLK; i++)
      if (a >= FLC_BLK_BASE[i]) blk_of = FLC_BW'(i);
  endfunction
endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [FLC_AW-1:0] addr,
  input  logic [FLC_DW-1:0] data,
  output cmd_t              cmd
);
  logic [FLC_CAW-1:0] low_addr;

  assign low_addr     = addr[FLC_CAW-1:0];
  assign cmd.at_unlk1 = (low_addr == ADR_UNLK1);
  assign cmd.at_unlk2 = (low_addr == ADR_UNLK2);
  assign cmd.code     = data[7:0];
endmodule

// File: rtl/erase_window.sv
module erase_window
  import flash_cmd_pkg::*;
#(
  parameter int WIN_CYC = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                add_en,
  input  logic [FLC_BW-1:0]   add_idx,
  input  logic                clr,
  output logic [FLC_NBLK-1:0] mask,
  output logic                expired
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mask <= '0;
    end else begin
      if (add_en) begin
        cnt  <= '0;
        mask <= mask | (FLC_NBLK'(1) << add_idx);
      end else begin
        if (!expired) cnt <= cnt + 1'b1;
        if (clr) mask <= '0;
      end
    end
  end

  assert_window_restart_R9: assert property (@(posedge clk) disable iff (rst)
    add_en |=> !expired);
  assert_window_grows_R9: assert property (@(posedge clk) disable iff (rst)
    add_en |=> mask[$past(add_idx)]);
endmodule

// File: rtl/id_read.sv
module id_read
  import flash_cmd_pkg::*;
#(
  parameter logic [FLC_DW-1:0] MFR_CODE = 16'h0020,
  parameter logic [FLC_DW-1:0] DEV_CODE = 16'h0097
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FLC_AW-1:0]   rd_addr,
  input  logic [FLC_NBLK-1:0] prot,
  output logic [FLC_DW-1:0]   id_word
);
  logic [FLC_DW-1:0] nxt_word;

  always_comb begin
    case (rd_addr[1:0])
      2'b00:   nxt_word = MFR_CODE;
      2'b01:   nxt_word = DEV_CODE;
      2'b10:   nxt_word = {{(FLC_DW-1){1'b0}}, prot[blk_of(rd_addr)]};
      default: nxt_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) id_word <= '0;
    else     id_word <= nxt_word;
  end

  assert_protect_word_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr[1:0]) == 2'b10 |-> id_word[FLC_DW-1:1] == '0);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int                WIN_CYC  = 32,
  parameter logic [FLC_DW-1:0] MFR_CODE = 16'h0020,
  parameter logic [FLC_DW-1:0] DEV_CODE = 16'h0097
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic [FLC_AW-1:0]   wr_addr,
  input  logic [FLC_DW-1:0]   wr_data,
  input  logic [FLC_AW-1:0]   rd_addr,
  input  logic [FLC_NBLK-1:0] prot,
  input  logic                eng_done,
  input  logic                eng_fail,
  output logic                start_prog,
  output logic [FLC_AW-1:0]   op_addr,
  output logic [FLC_DW-1:0]   op_data,
  output logic                start_erase,
  output logic [FLC_NBLK-1:0] erase_mask,
  output logic                abort_req,
  output logic                suspend_req,
  output logic                resume_req,
  output logic                win_closed,
  output logic                bypass_on,
  output logic [1:0]          rd_sel,
  output logic [FLC_DW-1:0]   id_word
);
  cmd_t                cmd;
  fst_t                st, nxt;
  logic                erase_op, nerase_op, nbyp;
  logic                p_prog, p_erase, p_abort, p_susp, p_res, p_win;
  logic                w_add, w_clr, w_exp;
  logic [FLC_NBLK-1:0] w_mask, n_mask, unprot;
  logic [1:0]          n_sel;

  cmd_match u_match (.addr(wr_addr), .data(wr_data), .cmd(cmd));

  erase_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .add_en(w_add), .add_idx(blk_of(wr_addr)),
    .clr(w_clr), .mask(w_mask), .expired(w_exp));

  id_read #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .prot(prot), .id_word(id_word));

  assign unprot = ~prot;

  always_comb begin
    nxt = st; nerase_op = erase_op; nbyp = bypass_on;
    p_prog = 1'b0; p_erase = 1'b0; p_abort = 1'b0; p_susp = 1'b0;
    p_res = 1'b0; p_win = 1'b0; w_add = 1'b0; w_clr = 1'b0;
    n_mask = '0;
    case (st)
      ST_READ, ST_AUTO: if (wr_valid) begin
        if (cmd.code == 8'hF0)                     nxt = ST_READ;
        else if (cmd.at_unlk1 && cmd.code == 8'hAA) nxt = ST_U1;
        else                                       nxt = ST_READ;
      end
      ST_U1: if (wr_valid)
        nxt = (cmd.at_unlk2 && cmd.code == 8'h55) ? ST_U2 : ST_READ;
      ST_U2: if (wr_valid) begin
        nxt = ST_READ;
        if (cmd.at_unlk1) begin
          case (cmd.code)
            8'h90: nxt = ST_AUTO;
            8'hA0: nxt = ST_PROG;
            8'h80: nxt = ST_E0;
            8'h20: begin nxt = ST_BYP; nbyp = 1'b1; end
            default: nxt = ST_READ;
          endcase
        end
      end
      ST_PROG: if (wr_valid) begin
        if (prot[blk_of(wr_addr)]) begin
          nxt = bypass_on ? ST_BYP : ST_READ;
        end else begin
          p_prog = 1'b1; nerase_op = 1'b0; nxt = ST_BUSY;
        end
      end
      ST_E0: if (wr_valid)
        nxt = (cmd.at_unlk1 && cmd.code == 8'hAA) ? ST_E1 : ST_READ;
      ST_E1: if (wr_valid)
        nxt = (cmd.at_unlk2 && cmd.code == 8'h55) ? ST_E2 : ST_READ;
      ST_E2: if (wr_valid) begin
        nxt = ST_READ;
        if (cmd.at_unlk1 && cmd.code == 8'h10) begin
          if (unprot != '0) begin
            p_erase = 1'b1; n_mask = unprot; nerase_op = 1'b1; nxt = ST_BUSY;
          end
        end else if (cmd.code == 8'h30) begin
          w_add = 1'b1; nxt = ST_WIN;
        end
      end
      ST_WIN: begin
        if (wr_valid) begin
          if (cmd.code == 8'h30) w_add = 1'b1;
          else begin w_clr = 1'b1; nxt = ST_READ; end
        end else if (w_exp) begin
          w_clr = 1'b1;
          nxt   = ST_READ;
          if ((w_mask & unprot) != '0) begin
            p_erase = 1'b1; p_win = 1'b1; n_mask = w_mask & unprot;
            nerase_op = 1'b1; nxt = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (eng_done) begin
          if (eng_fail)       nxt = ST_ERR;
          else if (bypass_on) nxt = ST_BYP;
          else                nxt = ST_READ;
        end else if (wr_valid && erase_op && cmd.code == 8'hB0) begin
          p_susp = 1'b1; nxt = ST_SUSP;
        end
      end
      ST_SUSP: if (wr_valid && cmd.code == 8'h30) begin
        p_res = 1'b1; nxt = ST_BUSY;
      end
      ST_ERR: if (wr_valid && cmd.code == 8'hF0) begin
        p_abort = 1'b1;
        nxt = bypass_on ? ST_BYP : ST_READ;
      end
      ST_BYP: if (wr_valid) begin
        if (cmd.code == 8'hA0)      nxt = ST_PROG;
        else if (cmd.code == 8'h90) nxt = ST_BEXIT;
      end
      ST_BEXIT: if (wr_valid) begin
        if (cmd.code == 8'h00) begin nxt = ST_READ; nbyp = 1'b0; end
        else                        nxt = ST_BYP;
      end
      default: nxt = ST_READ;
    endcase
  end

  always_comb begin
    case (nxt)
      ST_AUTO:                 n_sel = RD_ID;
      ST_BUSY, ST_ERR, ST_WIN: n_sel = RD_STATUS;
      default:                 n_sel = RD_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_READ;
      erase_op    <= 1'b0;
      bypass_on   <= 1'b0;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      abort_req   <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      win_closed  <= 1'b0;
      rd_sel      <= RD_ARRAY;
      op_addr     <= '0;
      op_data     <= '0;
      erase_mask  <= '0;
    end else begin
      st          <= nxt;
      erase_op    <= nerase_op;
      bypass_on   <= nbyp;
      start_prog  <= p_prog;
      start_erase <= p_erase;
      abort_req   <= p_abort;
      suspend_req <= p_susp;
      resume_req  <= p_res;
      rd_sel      <= n_sel;
      if (p_prog) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (p_erase) erase_mask <= n_mask;
      if (p_win) win_closed <= 1'b1;
      else if (st == ST_BUSY && eng_done) win_closed <= 1'b0;
    end
  end

  assert_prog_status_R5: assert property (@(posedge clk) disable iff (rst)
    start_prog |-> rd_sel == RD_STATUS);
  assert_erase_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    start_erase |-> (erase_mask != '0 && rd_sel == RD_STATUS));
  assert_suspend_array_R10: assert property (@(posedge clk) disable iff (rst)
    suspend_req |-> rd_sel == RD_ARRAY);
  assert_resume_status_R10: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> rd_sel == RD_STATUS);
  assert_one_request_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_prog, start_erase, abort_req, suspend_req, resume_req}));
  assert_bypass_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_on) |-> $past(wr_valid));
  assert_window_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(win_closed) |-> start_erase);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int WIN = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [4:0]  prot = '0;
  logic        eng_done = 1'b0, eng_fail = 1'b0;
  logic        start_prog, start_erase, abort_req, suspend_req, resume_req;
  logic        win_closed, bypass_on;
  logic [15:0] op_addr, op_data, id_word;
  logic [4:0]  erase_mask;
  logic [1:0]  rd_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.WIN_CYC(WIN)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .prot(prot), .eng_done(eng_done),
    .eng_fail(eng_fail), .start_prog(start_prog), .op_addr(op_addr),
    .op_data(op_data), .start_erase(start_erase), .erase_mask(erase_mask),
    .abort_req(abort_req), .suspend_req(suspend_req), .resume_req(resume_req),
    .win_closed(win_closed), .bypass_on(bypass_on), .rd_sel(rd_sel),
    .id_word(id_word));

  function automatic int exp_blk(input logic [15:0] a);
    if (a[15])                 return 4;
    else if (a[14])            return 3;
    else if (a[13:12] == 2'b11) return 2;
    else if (a[13:12] == 2'b10) return 1;
    else                       return 0;
  endfunction

  function automatic logic [15:0] exp_id(input logic [15:0] a, input logic [4:0] p);
    case (a[1:0])
      2'b00:   return 16'h0020;
      2'b01:   return 16'h0097;
      2'b10:   return {15'd0, p[exp_blk(a)]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic op_end(input logic fail);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = fail;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic id_chk(input logic [15:0] a, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(tag, id_word, exp_id(a, prot));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20250917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 bypass_on", bypass_on, 0);
    chk("R1 pulses", {start_prog, start_erase, abort_req, suspend_req, resume_req}, 0);

    // R4: identifier mode
    prot = 5'b00100;
    unlock(); wr(16'h0555, 16'h0090);
    chk("R4 rd_sel id", rd_sel, 1);
    id_chk(16'h1230, "R4 manufacturer");
    id_chk(16'hF001, "R4 device");
    id_chk(16'h3002, "R4 protected block");
    id_chk(16'h8002, "R4 unprotected block");
    for (int i = 0; i < 20; i++) begin
      prot = 5'($urandom);
      id_chk(16'($urandom), "R4 random id read");
    end
    // R6: single-write reset from identifier mode
    wr(16'h7777, 16'h00F0);
    chk("R6 single reset", rd_sel, 0);
    // R6: prefixed reset from identifier mode
    unlock(); wr(16'h0555, 16'h0090);
    unlock(); wr(16'h0123, 16'h00F0);
    chk("R6 prefixed reset", rd_sel, 0);

    // R2 + R5: program with high bits set on command writes
    prot = 5'b00000;
    wr(16'hF555, 16'hC3AA); wr(16'hA2AA, 16'h7755); wr(16'h5555, 16'hFFA0);
    wr(16'h4321, 16'hBEEF);
    chk("R2 high bits ignored start", start_prog, 1);
    chk("R5 op_addr", op_addr, 16'h4321);
    chk("R5 op_data", op_data, 16'hBEEF);
    chk("R5 rd_sel status", rd_sel, 2);
    // R10: writes ignored during program
    wr(16'h0000, 16'h00F0);
    chk("R10 ignored write status", rd_sel, 2);
    chk("R10 no abort", abort_req, 0);
    wr(16'h0000, 16'h00B0);
    chk("R10 no suspend in program", suspend_req, 0);
    op_end(1'b0);
    chk("R5 done to array", rd_sel, 0);
    // R5: protected target
    prot = 5'b01000;
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h5000, 16'h1234);
    chk("R5 protected no start", start_prog, 0);
    chk("R5 protected rd_sel", rd_sel, 0);

    // R3: broken sequences at random steps
    prot = 5'b00000;
    for (int i = 0; i < 24; i++) begin
      int step;
      step = int'($urandom % 3);
      if (step == 0) wr(16'h0555, 16'(($urandom % 255) & 16'h00FE));
      else begin
        wr(16'h0555, 16'h00AA);
        if (step == 1) wr(16'h02AA, 16'h0056 + 16'($urandom % 8));
        else begin wr(16'h02AA, 16'h0055); wr(16'h0556, 16'h00A0); end
      end
      wr(16'h0555, 16'h00A0);
      wr(16'($urandom), 16'($urandom));
      chk("R3 broken sequence no start", start_prog, 0);
      chk("R3 broken sequence read mode", rd_sel, 0);
    end

    // R5: random programs under random protection
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a, d;
      logic        exp_go;
      a = 16'($urandom); d = 16'($urandom); prot = 5'($urandom);
      exp_go = !prot[exp_blk(a)];
      unlock(); wr(16'h0555, 16'h00A0); wr(a, d);
      chk("R5 random start", start_prog, exp_go);
      if (exp_go) begin
        chk("R5 random addr", op_addr, a);
        chk("R5 random data", op_data, d);
        op_end(1'b0);
      end
      chk("R5 random end rd_sel", rd_sel, 0);
    end

    // R7: bypass mode
    prot = 5'b00000;
    unlock(); wr(16'h0555, 16'h0020);
    chk("R7 bypass on", bypass_on, 1);
    chk("R7 bypass reads array", rd_sel, 0);
    wr(16'h0555, 16'h00AA);
    wr(16'h0000, 16'h00F0);
    chk("R7 other writes ignored", bypass_on, 1);
    wr(16'h1111, 16'h00A0); wr(16'h2468, 16'h5A5A);
    chk("R7 bypass program start", start_prog, 1);
    chk("R7 bypass program addr", op_addr, 16'h2468);
    op_end(1'b0);
    chk("R7 back in bypass", bypass_on, 1);
    chk("R7 bypass rd_sel", rd_sel, 0);
    // R11 + R12: error inside bypass
    wr(16'h0000, 16'h00A0); wr(16'h9ABC, 16'h0F0F);
    op_end(1'b1);
    chk("R11 error status", rd_sel, 2);
    wr(16'h0555, 16'h00AA);
    chk("R12 error write ignored", rd_sel, 2);
    chk("R12 no abort", abort_req, 0);
    wr(16'h0000, 16'h00F0);
    chk("R11 abort pulse", abort_req, 1);
    chk("R11 stays bypass", bypass_on, 1);
    chk("R11 bypass read", rd_sel, 0);
    wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000);
    chk("R7 bypass exit", bypass_on, 0);
    // R11: error outside bypass
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h0001);
    op_end(1'b1);
    chk("R11 error status plain", rd_sel, 2);
    wr(16'h0000, 16'h00F0);
    chk("R11 abort plain", abort_req, 1);
    chk("R11 read mode", rd_sel, 0);

    // R8: chip erase
    prot = 5'b00101;
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0555, 16'h0010);
    chk("R8 chip start", start_erase, 1);
    chk("R8 chip mask", erase_mask, 5'b11010);
    op_end(1'b0);
    prot = 5'b11111;
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0555, 16'h0010);
    chk("R8 all protected no start", start_erase, 0);
    chk("R8 all protected read", rd_sel, 0);

    // R9 + R10: block erase with window, suspend and resume
    prot = 5'b00000;
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h2100, 16'h0030);
    chk("R9 window status", rd_sel, 2);
    wr(16'h9000, 16'h0030);
    repeat (WIN - 1) @(negedge clk);
    chk("R9 not before window", start_erase, 0);
    @(negedge clk);
    chk("R9 erase start", start_erase, 1);
    chk("R9 erase mask", erase_mask, 5'b10010);
    chk("R9 window closed", win_closed, 1);
    wr(16'h0000, 16'h00B0);
    chk("R10 suspend pulse", suspend_req, 1);
    chk("R10 suspended reads array", rd_sel, 0);
    wr(16'h0000, 16'h0030);
    chk("R10 resume pulse", resume_req, 1);
    chk("R10 resumed status", rd_sel, 2);
    op_end(1'b0);
    chk("R9 window flag cleared", win_closed, 0);
    chk("R9 done read", rd_sel, 0);

    summary();
    $finish;
  end
endmodule